// File: doc/BRIEF.md
# Configurable-Period Software Watchdog

This block watches a processor's software for signs of life. Software keeps it quiet by toggling a kick input. A high-to-low transition restarts the countdown. If no such transition arrives within the chosen period, the block sends a single-cycle request to the chip's reset generator. The reset generator then drives the system reset for its standard pulse. Period length is measured in ticks of an external millisecond strobe. The tick counts for the three selectable periods are parameters, so a fast bench can shrink them.

A byte-wide control register holds a two-bit period code and is loaded through a plain write port. The code values are:

- 00 turns the watchdog off.
- 01 selects the short period.
- 10 selects the middle period.
- 11 selects the long period.

Counting only takes place while the system reset line is inactive. While that line is active, the counter is held at its reload value and re-armed. After a timeout the block stays silent until the system reset has been seen again.

Top module: `wdog_timer`

## Requirements
- R1: After `rst_n` is low, `wd_cfg` reads 8'h03: period code 11, long period enabled. Bits 7 to 2 of `wd_cfg` always read zero.
- R2: A write (`cfg_wr` high for one cycle) stores `cfg_wdata[1:0]` into `wd_cfg[1:0]` from the next cycle on. Bits 7 to 2 of the written data are ignored.
- R3: With code 01, 10 or 11, the request fires on the P_SHORT-th, P_MID-th or P_LONG-th `ms_tick` after the last reload, respectively.
- R4: With code 00, no request is ever issued and counting stops.
- R5: While `host_rst_active` is high, no request is issued, whatever the number of ticks. The counter is held at the reload value.
- R6: A falling edge on `kick_in` reloads the full period. Detection passes through a two-flop synchronizer plus an edge flop, so the reload takes effect on the third clock edge after the change. Rising edges and steady levels have no effect.
- R7: `bite_req` is high for exactly one clock cycle per timeout. It rises on the clock edge that samples the expiring tick.
- R8: After a timeout, no further request is issued until `host_rst_active` has been high again.
- R9: A write reloads the counter with the period of the newly written code. No request is issued in the cycle that follows a write, so writing 00 also cancels a pending expiry.
- R10: Timing of the first period starts when `host_rst_active` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| host_rst_active | input | 1 | High while the system reset line is active |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| kick_in | input | 1 | Asynchronous kick from software |
| cfg_wr | input | 1 | Register write enable |
| cfg_wdata | input | 8 | Register write data |
| wd_cfg | output | 8 | Register readback |
| bite_req | output | 1 | One-cycle timeout request to the reset generator |

## Verification
The assertions assume a few things about the inputs:

- `ms_tick` is a single-cycle pulse.
- A write and a tick never land on the same edge as the expiry that a property reasons about.
- `host_rst_active` is synchronous to `clk`.

The stimulus keeps to these assumptions by spacing ticks three cycles apart. It drives every input on the falling clock edge. Between a kick transition and the next tick, it leaves at least four cycles, so the synchronizer delay has elapsed before the next tick is counted.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int CFG_W  = 8;
   localparam int CODE_W = 2;

   typedef enum logic [CODE_W-1:0] {
      PC_OFF   = 2'b00,
      PC_SHORT = 2'b01,
      PC_MID   = 2'b10,
      PC_LONG  = 2'b11
   } pcode_e;
endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg
   import wdog_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_q
);
   logic [CODE_W-1:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      code_q <= PC_LONG;
      else if (cfg_wr) code_q <= cfg_wdata[CODE_W-1:0];
   end

   assign cfg_q = {{(CFG_W-CODE_W){1'b0}}, code_q};

   p_wr_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> cfg_q[CODE_W-1:0] == $past(cfg_wdata[CODE_W-1:0]));
   p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> cfg_q[CFG_W-1:CODE_W] == '0);
endmodule

// File: rtl/wdog_kick_edge.sv
module wdog_kick_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick_in,
   output logic kick_fall
);
   logic [SYNC_STAGES:0] chain;

   for (genvar i = 0; i <= SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= kick_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign kick_fall = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];

   p_fall_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      kick_fall |=> !kick_fall);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
   import wdog_pkg::*;
#(
   parameter int P_SHORT = 250,
   parameter int P_MID   = 500,
   parameter int P_LONG  = 1000,
   localparam int CNT_W  = $clog2(P_LONG + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_rst_active,
   input  logic              ms_tick,
   input  logic              kick_fall,
   input  logic              cfg_wr,
   input  logic [CODE_W-1:0] wr_code,
   input  logic [CODE_W-1:0] cur_code,
   output logic              bite_q
);
   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;

   function automatic logic [CNT_W-1:0] reload(input logic [CODE_W-1:0] code);
      case (pcode_e'(code))
         PC_SHORT: reload = CNT_W'(P_SHORT);
         PC_MID:   reload = CNT_W'(P_MID);
         default:  reload = CNT_W'(P_LONG);
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= CNT_W'(P_LONG);
         armed_q <= 1'b1;
         bite_q  <= 1'b0;
      end else begin
         bite_q <= 1'b0;
         if (host_rst_active) begin
            cnt_q   <= reload(cur_code);
            armed_q <= 1'b1;
         end else if (cfg_wr) begin
            cnt_q <= reload(wr_code);
         end else if (cur_code == PC_OFF || !armed_q) begin
            cnt_q <= cnt_q;
         end else if (kick_fall) begin
            cnt_q <= reload(cur_code);
         end else if (ms_tick) begin
            if (cnt_q == CNT_W'(1)) begin
               bite_q  <= 1'b1;
               armed_q <= 1'b0;
               cnt_q   <= reload(cur_code);
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   p_pulse_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bite_q |=> !bite_q);
   p_hold_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      host_rst_active |=> !bite_q);
   p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_code == PC_OFF) |=> !bite_q);
   p_wr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> !bite_q);
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !host_rst_active) |=> !bite_q);
   p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q != '0 && cnt_q <= CNT_W'(P_LONG));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdog_pkg::*;
#(
   parameter int P_SHORT     = 250,
   parameter int P_MID       = 500,
   parameter int P_LONG      = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_rst_active,
   input  logic             ms_tick,
   input  logic             kick_in,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] wd_cfg,
   output logic             bite_req
);
   if (P_SHORT < 1) begin : g_bad_short
      $error("P_SHORT must be at least 1");
   end
   if (!(P_SHORT < P_MID && P_MID < P_LONG)) begin : g_bad_order
      $error("periods must rise strictly from short to long");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic kick_fall;

   wdog_cfg_reg i_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_wdata (cfg_wdata),
      .cfg_q     (wd_cfg)
   );

   wdog_kick_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .kick_in   (kick_in),
      .kick_fall (kick_fall)
   );

   wdog_counter #(.P_SHORT(P_SHORT), .P_MID(P_MID), .P_LONG(P_LONG)) i_cnt (
      .clk             (clk),
      .rst_n           (rst_n),
      .host_rst_active (host_rst_active),
      .ms_tick         (ms_tick),
      .kick_fall       (kick_fall),
      .cfg_wr          (cfg_wr),
      .wr_code         (cfg_wdata[CODE_W-1:0]),
      .cur_code        (wd_cfg[CODE_W-1:0]),
      .bite_q          (bite_req)
   );
endmodule

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
   localparam int PS = 3, PM = 5, PL = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_rst_active = 1'b1;
   logic       ms_tick = 1'b0;
   logic       kick_in = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] wd_cfg;
   logic       bite_req;

   int checks = 0, errors = 0, cyc = 0;
   int    exp_q[$];
   string tag_q[$];
   logic  prev_bite = 1'b0;
   bit    done = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wdog_timer #(.P_SHORT(PS), .P_MID(PM), .P_LONG(PL)) i_wdog_timer (
      .clk(clk), .rst_n(rst_n), .host_rst_active(host_rst_active),
      .ms_tick(ms_tick), .kick_in(kick_in), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .wd_cfg(wd_cfg), .bite_req(bite_req));

   // monitor: pops expected timeout stamps and compares
   always @(negedge clk) begin
      if (rst_n) begin
         if (bite_req && prev_bite) begin
            checks++; errors++;
            $display("FAIL R7 pulse wider than one cycle: actual 2+ cycles expected 1");
         end
         if (bite_req) begin
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL unexpected timeout at cycle %0d: actual 1 expected 0", cyc);
            end else begin
               int    e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (e != cyc) begin
                  errors++;
                  $display("FAIL %s timeout cycle: actual %0d expected %0d", t, cyc, e);
               end
            end
         end
      end
      prev_bite = bite_req;
   end

   task automatic check_eq(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic expect_drained(string req);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL %s missing timeout: actual 0 expected %0d pending", req, exp_q.size());
         exp_q.delete();
         tag_q.delete();
      end
   endtask

   task automatic do_ticks(int n, int fire_at, string req);
      for (int i = 1; i <= n; i++) begin
         @(negedge clk);
         ms_tick = 1'b1;
         if (i == fire_at) begin
            exp_q.push_back(cyc + 1);
            tag_q.push_back(req);
         end
         @(negedge clk);
         ms_tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic write_cfg(logic [7:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rearm();
      @(negedge clk);
      host_rst_active = 1'b1;
      repeat (2) @(negedge clk);
      host_rst_active = 1'b0;
   endtask

   task automatic set_kick(logic v);
      @(negedge clk);
      kick_in = v;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R1 reset cfg", int'(wd_cfg), 8'h03);
      check_eq("R1 no request in reset", int'(bite_req), 0);

      // R5: ticks while system reset active
      do_ticks(2 * PL, 0, "R5");
      expect_drained("R5");

      // R10 / R3 long: start timing at release
      host_rst_active = 1'b0;
      do_ticks(PL, PL, "R10 long period");
      expect_drained("R10");
      // R8: silence after timeout
      do_ticks(2 * PL, 0, "R8");
      expect_drained("R8");

      // R2: write, upper bits ignored
      rearm();
      write_cfg(8'hFD);
      check_eq("R2 write code 01 upper ignored", int'(wd_cfg), 8'h01);
      do_ticks(PS, PS, "R3 short period");
      expect_drained("R3 short");

      rearm();
      write_cfg(8'h02);
      check_eq("R2 write code 10", int'(wd_cfg), 8'h02);
      do_ticks(PM, PM, "R3 mid period");
      expect_drained("R3 mid");

      // R6: falling kick reloads
      rearm();
      set_kick(1'b1);
      do_ticks(PM - 1, 0, "R6");
      set_kick(1'b0);
      do_ticks(PM, PM, "R6 fall reload");
      expect_drained("R6 fall");

      // R6: rising edge has no effect
      rearm();
      do_ticks(2, 0, "R6");
      set_kick(1'b1);
      do_ticks(PM - 2, PM - 2, "R6 rise ignored");
      expect_drained("R6 rise");
      set_kick(1'b0);

      // R4: write 00 stops counting
      rearm();
      do_ticks(PM - 1, 0, "R4");
      write_cfg(8'h00);
      check_eq("R4 cfg off", int'(wd_cfg), 0);
      do_ticks(2 * PL, 0, "R4");
      expect_drained("R4 off");

      // R9: write reloads with new period
      write_cfg(8'h01);
      do_ticks(PS, PS, "R9 reload after off");
      expect_drained("R9 off");

      rearm();
      write_cfg(8'h03);
      do_ticks(PL - 2, 0, "R9");
      write_cfg(8'h02);
      do_ticks(PM, PM, "R9 reload mid count");
      expect_drained("R9 mid");
      check_eq("R7 request low after pulse", int'(bite_req), 0);

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog expired: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule